// File: doc/BRIEF.md
# Strobe Sample Classifier

This block runs one sampling pass over a memory channel's data strobes. At the end it reports whether every strobe bit it saw was high, every bit was low, or the bits were mixed. Receive-enable training logic uses it. That logic moves a delay setting, starts a pass, and reads the verdict to decide where the next step goes.

A pass works as follows:
- An accepted start produces a one-cycle clear pulse on `sample_clear` for the external sampling logic. The same pulse resets the internal reduction state.
- The block then issues a fixed train of paired reads on a valid/ready request port. The first read of each pair goes to a base address and the second goes to the base plus 0x80.
- For each returned burst it captures the strobe lines and folds them into running AND and OR reductions.
- The base address depends on the channel index, on the interleave mode and on an 8-bit rank-boundary value.

On the request port, `rd_req_valid` and `rd_req_addr` stay steady until `rd_req_ready` accepts them, so the memory side may stall as long as it likes. Only one read is outstanding at a time. The block raises `rd_rsp_ready` only while it waits for that read's burst, and a burst counts only in a cycle where both `rd_rsp_valid` and `rd_rsp_ready` are high.

Top module: `strobe_classifier`

## Requirements
- R1: A start pulse seen while idle makes `sample_clear` high for exactly the following cycle. The first read request appears in the cycle after that.
- R2: A pass issues exactly 56 accepted read requests (28 pairs). Even-numbered requests, counting from 0, go to the base address and odd-numbered ones go to base + 0x80.
- R3: For channel 0 (`chan_sel`=0) the base address is 0, whatever the value of `interleave`.
- R4: For channel 1 with `interleave`=1 the base address is 0x0000_0040.
- R5: For channel 1 with `interleave`=0 the base address is `rank_bound` shifted left by 25, truncated to 32 bits.
- R6: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid and its address does not change. No new request is made while a burst is awaited.
- R7: `status` bit 19 is 1 after a pass in which every captured strobe bit was 1.
- R8: `status` bit 18 is 1 after a pass in which every captured strobe bit was 0.
- R9: After a mixed pass both bits 18 and 19 are 0. The two bits are never 1 together, and all other `status` bits are always 0.
- R10: `done` is high for exactly one cycle, in the cycle after the last burst is accepted. `status` takes the verdict in that same cycle and keeps it until the next accepted start clears it to 0.
- R11: A start pulse that arrives while a pass is running is ignored. It causes no clear pulse, and the channel inputs are not re-sampled.
- R12: Channel, interleave and rank-boundary inputs are sampled when a start is accepted. Both channels report their flags at bits 19 and 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (taken only while idle) |
| chan_sel | input | 1 | Channel index, 0 or 1 |
| interleave | input | 1 | Channels interleaved when 1 |
| rank_bound | input | 8 | Rank-boundary value used for the channel 1 base |
| busy | output | 1 | A pass is in progress |
| sample_clear | output | 1 | One-cycle clear pulse for the strobe sampling logic |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read request address |
| rd_rsp_valid | input | 1 | Burst strobes valid |
| rd_rsp_ready | output | 1 | Block waits for a burst |
| rd_rsp_strobe | input | 8 | Captured strobe lines of the burst |
| done | output | 1 | Pass finished, one-cycle pulse |
| status | output | 32 | Verdict word: bit 19 all-high, bit 18 all-low |

## Verification
The bench uses the default parameters: 28 read pairs, 8 strobe lines and a 32-bit address. With these values the top rank-boundary bit is shifted out of the address, so a value of 0xFF checks the truncation. The full 56-read count and its pair alternation are checked under request stalls and response latencies drawn from an LFSR. The strobe patterns include a single low bit in the middle of the pass, a single high bit in the very last burst, and bursts that alternate between all ones and all zeros. Together they show that the reductions cover every burst, including the last one.

// File: rtl/strb_pkg.sv
package strb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_REQ   = 2'd2,
    ST_RSP   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/strb_base_addr.sv
module strb_base_addr #(
  parameter int ADDR_W      = 32,
  parameter int CFG_W       = 8,
  parameter int RANK_SHIFT  = 25,
  parameter int IL_BIT      = 6,
  parameter int PAIR_STRIDE = 128
) (
  input  logic              chan,
  input  logic              interleave,
  input  logic [CFG_W-1:0]  rank_bound,
  input  logic              odd,
  output logic [ADDR_W-1:0] addr
);
  localparam int WIDE_W = ADDR_W + CFG_W;

  logic [WIDE_W-1:0] rank_wide;
  logic [ADDR_W-1:0] base;

  always_comb begin
    rank_wide = {{ADDR_W{1'b0}}, rank_bound} << RANK_SHIFT;
    if (!chan)
      base = '0;
    else if (interleave)
      base = ADDR_W'(1) << IL_BIT;
    else
      base = rank_wide[ADDR_W-1:0];
    addr = base + (odd ? ADDR_W'(PAIR_STRIDE) : '0);
  end
endmodule

// File: rtl/strb_seq.sv
module strb_seq
  import strb_pkg::*;
#(
  parameter int ITERS = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic accept,
  output logic busy,
  output logic clear,
  output logic req_valid,
  output logic rsp_ready,
  output logic odd,
  output logic sample_en,
  output logic finish,
  output logic done
);
  localparam int RD_CNT = 2 * ITERS;
  localparam int CNT_W  = $clog2(RD_CNT + 1);

  seq_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic done_q;
  logic last;

  assign last      = (cnt_q == CNT_W'(RD_CNT - 1));
  assign accept    = (state_q == ST_IDLE) && start;
  assign busy      = (state_q != ST_IDLE);
  assign clear     = (state_q == ST_CLEAR);
  assign req_valid = (state_q == ST_REQ);
  assign rsp_ready = (state_q == ST_RSP);
  assign sample_en = rsp_ready && rsp_valid;
  assign finish    = sample_en && last;
  assign odd       = cnt_q[0];
  assign done      = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_CLEAR;
      ST_CLEAR: state_d = ST_REQ;
      ST_REQ:   if (req_ready) state_d = ST_RSP;
      ST_RSP:   if (rsp_valid) state_d = last ? ST_IDLE : ST_REQ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (clear)
        cnt_q <= '0;
      else if (sample_en)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: a clear pulse lasts one cycle and is followed by a request
  a_r1_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!clear && req_valid));
  // R11: a clear only ever follows a start taken while idle
  a_r11_clear_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clear) |-> $past(accept));
  // R6: one outstanding read
  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rsp_ready);
  // R2: the counter never passes the read count
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(RD_CNT));
endmodule

// File: rtl/strb_accum.sv
module strb_accum #(
  parameter int STROBE_W  = 8,
  parameter int STAT_W    = 32,
  parameter int HI_BIT    = 19,
  parameter int LO_BIT    = 18,
  parameter int CH0_SHIFT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                sample_en,
  input  logic                finish,
  input  logic                chan,
  input  logic [STROBE_W-1:0] strobe,
  output logic [STAT_W-1:0]   status
);
  logic [STROBE_W-1:0] and_q, or_q, and_n, or_n;
  logic [STAT_W-1:0]   raw, norm, status_q;
  logic                all_hi, all_lo;

  always_comb begin
    and_n  = and_q & strobe;
    or_n   = or_q | strobe;
    all_hi = &and_n;
    all_lo = ~|or_n;
    // channel 0 flags sit two lanes lower in the raw word
    raw = '0;
    if (chan) begin
      raw[HI_BIT] = all_hi;
      raw[LO_BIT] = all_lo;
    end else begin
      raw[HI_BIT-CH0_SHIFT] = all_hi;
      raw[LO_BIT-CH0_SHIFT] = all_lo;
    end
    norm = chan ? raw : (raw << CH0_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      and_q    <= '1;
      or_q     <= '0;
      status_q <= '0;
    end else if (clear) begin
      and_q    <= '1;
      or_q     <= '0;
      status_q <= '0;
    end else if (sample_en) begin
      and_q <= and_n;
      or_q  <= or_n;
      if (finish) status_q <= norm;
    end
  end

  assign status = status_q;

  // R9: the two flags are never set together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[HI_BIT] && status[LO_BIT]));
  // R10: the verdict holds between updates
  a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!finish && !clear) |=> $stable(status));
endmodule

// File: rtl/strobe_classifier.sv
module strobe_classifier #(
  parameter int ITERS       = 28,
  parameter int STROBE_W    = 8,
  parameter int ADDR_W      = 32,
  parameter int CFG_W       = 8,
  parameter int STAT_W      = 32,
  parameter int RANK_SHIFT  = 25,
  parameter int IL_BIT      = 6,
  parameter int PAIR_STRIDE = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                chan_sel,
  input  logic                interleave,
  input  logic [CFG_W-1:0]    rank_bound,
  output logic                busy,
  output logic                sample_clear,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [ADDR_W-1:0]   rd_req_addr,
  input  logic                rd_rsp_valid,
  output logic                rd_rsp_ready,
  input  logic [STROBE_W-1:0] rd_rsp_strobe,
  output logic                done,
  output logic [STAT_W-1:0]   status
);
  logic             accept, odd, sample_en, finish;
  logic             chan_q, il_q;
  logic [CFG_W-1:0] rank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= 1'b0;
      il_q   <= 1'b0;
      rank_q <= '0;
    end else if (accept) begin
      chan_q <= chan_sel;
      il_q   <= interleave;
      rank_q <= rank_bound;
    end
  end

  strb_seq #(.ITERS(ITERS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_ready (rd_req_ready),
    .rsp_valid (rd_rsp_valid),
    .accept    (accept),
    .busy      (busy),
    .clear     (sample_clear),
    .req_valid (rd_req_valid),
    .rsp_ready (rd_rsp_ready),
    .odd       (odd),
    .sample_en (sample_en),
    .finish    (finish),
    .done      (done)
  );

  strb_base_addr #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W), .RANK_SHIFT(RANK_SHIFT),
    .IL_BIT(IL_BIT), .PAIR_STRIDE(PAIR_STRIDE)
  ) u_addr (
    .chan       (chan_q),
    .interleave (il_q),
    .rank_bound (rank_q),
    .odd        (odd),
    .addr       (rd_req_addr)
  );

  strb_accum #(.STROBE_W(STROBE_W), .STAT_W(STAT_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (sample_clear),
    .sample_en (sample_en),
    .finish    (finish),
    .chan      (chan_q),
    .strobe    (rd_rsp_strobe),
    .status    (status)
  );

  // R6: a stalled request holds its address
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R12: configuration is held for the whole pass
  a_r12_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sample_clear) |=> ($stable(chan_q) && $stable(rank_q)));
endmodule

// File: tb/strobe_classifier_bench.sv
module strobe_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREADS = 56;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        chan_sel = 1'b0, interleave = 1'b0;
  logic [7:0]  rank_bound = '0;
  logic        busy, sample_clear, rd_req_valid, rd_rsp_ready, done;
  logic        rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_strobe = '0;
  logic [31:0] rd_req_addr, status;

  strobe_classifier u_strobe_classifier (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .interleave(interleave), .rank_bound(rank_bound), .busy(busy),
    .sample_clear(sample_clear), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_strobe(rd_rsp_strobe), .done(done), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_errors = 0, dones = 0;
  int req_idx = 0, rd_idx = 0, cur_mode = 0;
  logic [31:0] cur_base = '0;
  typedef struct { logic [31:0] word; } exp_t;
  exp_t sb_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] strobe_for(input int idx);
    case (cur_mode)
      0: return 8'hFF;
      1: return 8'h00;
      2: return (idx == 17) ? 8'hF7 : 8'hFF;
      3: return (idx == NREADS-1) ? 8'h01 : 8'h00;
      default: return idx[0] ? 8'h00 : 8'hFF;
    endcase
  endfunction

  // memory model with LFSR-driven stalls and latency
  initial begin
    logic [7:0] lfsr = 8'h5A;
    bit pending = 0, rsp_fire = 0, stalled = 0;
    int lat = 0;
    logic [31:0] held = '0;
    forever begin
      @(negedge clk);
      if (stalled) begin
        check(rd_req_valid && rd_req_addr == held, "R6 stalled request held", rd_req_addr, held);
        stalled = 0;
      end
      if (rsp_fire) begin rd_rsp_valid = 1'b0; rsp_fire = 0; end
      if (pending) begin
        if (lat != 0) lat--;
        else if (!rd_rsp_valid) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_strobe = strobe_for(rd_idx);
        end
      end
      if (rd_rsp_valid && rd_rsp_ready) begin
        rsp_fire = 1; pending = 0; rd_idx++;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rd_req_ready = lfsr[0] | lfsr[3];
      if (rd_req_valid) begin
        check(!pending, "R6 no request while burst pending", 32'(pending), 32'd0);
        if (rd_req_ready) begin
          check(rd_req_addr == cur_base + (req_idx[0] ? 32'h80 : 32'h0),
                "R2/R3/R4/R5 request address", rd_req_addr,
                cur_base + (req_idx[0] ? 32'h80 : 32'h0));
          req_idx++;
          pending = 1;
          lat = int'(lfsr[2:1]);
        end else begin
          stalled = 1; held = rd_req_addr;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        logic [31:0] snap;
        if (sb_q.size() == 0) begin
          check(0, "R10 unexpected done", 32'd1, 32'd0);
        end else begin
          e = sb_q.pop_front();
          check(status == e.word, "R7/R8/R9 verdict word", status, e.word);
          check(req_idx == NREADS, "R2 request count", 32'(req_idx), 32'(NREADS));
        end
        snap = status;
        @(negedge clk);
        check(!done, "R10 done one cycle", 32'(done), 32'd0);
        check(status == snap, "R10 status held after done", status, snap);
        dones++;
      end
    end
  end

  task automatic run_pass(input bit ch, input bit il, input logic [7:0] rb, input int mode, input bit poke);
    exp_t e;
    logic [31:0] base;
    int target;
    base = !ch ? 32'h0 : (il ? 32'h40 : {rb[6:0], 25'b0});
    e.word = '0;
    if (mode == 0) e.word[19] = 1'b1;
    if (mode == 1) e.word[18] = 1'b1;
    sb_q.push_back(e);
    target = dones + 1;
    @(negedge clk);
    chan_sel = ch; interleave = il; rank_bound = rb;
    cur_base = base; cur_mode = mode; req_idx = 0; rd_idx = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(sample_clear, "R1 clear pulse after start", 32'(sample_clear), 32'd1);
    @(negedge clk);
    check(!sample_clear && rd_req_valid, "R1 clear then request",
          {30'd0, sample_clear, rd_req_valid}, 32'd1);
    check(status == 32'd0, "R10 status cleared by start", status, 32'd0);
    if (poke) begin
      repeat (5) @(negedge clk);
      chan_sel = ~ch; interleave = ~il; rank_bound = ~rb;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(!sample_clear, "R11 start while busy ignored", 32'(sample_clear), 32'd0);
    end
    while (dones < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !rd_req_valid && !busy && !sample_clear && status == 0,
          "R10 reset state", status, 32'd0);
    rst_n = 1'b1;
    run_pass(1'b0, 1'b0, 8'h33, 0, 1'b0); // R3 R7 channel 0 all high
    run_pass(1'b1, 1'b1, 8'h21, 1, 1'b0); // R4 R8 interleaved all low
    run_pass(1'b1, 1'b0, 8'h12, 2, 1'b0); // R5 R9 single low bit mid-pass
    run_pass(1'b1, 1'b0, 8'hFF, 3, 1'b0); // R5 truncation, R9 last burst counts
    run_pass(1'b0, 1'b1, 8'hAA, 4, 1'b0); // R3 interleave ignored on channel 0
    run_pass(1'b1, 1'b1, 8'h05, 0, 1'b1); // R11 R12 start while busy
    run_pass(1'b0, 1'b0, 8'h00, 1, 1'b0); // R12 channel 0 flag at bit 18
    check(sb_q.size() == 0, "R10 every pass finished", 32'(sb_q.size()), 32'd0);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule